// File: doc/BRIEF.md
# SMBus Device Transaction Sequencer

This block sits on top of a byte-level I2C target front end that has already matched the address and decoded the bus conditions. It takes the front end's event strobes (start of a write, start of a read, stop, master NACK, a received byte and a request for a byte to send) and turns them into device-level SMBus operations.

An empty transaction becomes a quick command that carries its direction. Bytes written by the host are collected in a bounded buffer. That buffer is handed to the application as one committed block, either at the stop or at a repeated start into a read. The first buffered byte is the command code.

During a read, each byte request is forwarded to the application. The application's byte is returned, and 0xFF is returned when the application offers none. Any event that arrives in an order the protocol does not allow latches a confused state, and only a stop leaves it. Each protocol error raises a one-cycle error pulse.

Top module: `smb_txn_seq`

## Requirements
- R1: After a synchronous reset the sequencer is idle with zero buffered length. No pulse output is high, and `txData` reads 0xFF.
- R2: A start-of-write in idle enters the write phase. In any other state it moves to confused and pulses `errPulse`.
- R3: In the write phase each received byte is stored at the next buffer position, and buffer index 0 holds the command code. A stop in the write phase with a nonzero length pulses `commitPulse` one cycle later. `commitCmd` then shows byte 0, `commitLen` shows the byte count, and `bufByte` shows entry `bufIdx`.
- R4: Every stop returns to idle with zero length. A stop with zero buffered bytes in the write phase or the read phase pulses `quickPulse`, with `quickDir` = 1 for the read phase and 0 for the write phase.
- R5: A start-of-read in idle enters the read phase. In the write phase with buffered bytes it commits them, pulsing `commitPulse` with their length, and enters the read phase in the same cycle. In the write phase with no bytes it moves to confused with an error.
- R6: A NACK in the read phase moves to the done state, and a NACK in the done state has no effect. A NACK in any other state moves to confused with an error.
- R7: Once the buffer holds `DEPTH` bytes, further received bytes are dropped, `errPulse` pulses for each of them, and the length stays at `DEPTH`.
- R8: A byte request in the read phase raises `appReq` and returns `appData` on `txData`, or 0xFF when `appValid` is low, without an error. In any other state it returns 0xFF, moves to confused and pulses `errPulse`.
- R9: A received byte outside the write phase is not stored and pulses `errPulse`.
- R10: A stop in the read phase with buffered bytes left by a repeated start pulses `errPulse` and issues neither a commit nor a quick command. A stop in the done or confused state issues nothing.
- R11: The confused state ignores every event except stop, and each start, NACK or byte request received there pulses `errPulse`.
- R12: Only one strobe is acted on per cycle, with priority stop > start-of-read > start-of-write > NACK > received byte > byte request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evStartWr | input | 1 | Start (or repeated start) addressed for writing |
| evStartRd | input | 1 | Start (or repeated start) addressed for reading |
| evStop | input | 1 | Stop condition |
| evNack | input | 1 | Host did not acknowledge the last byte sent |
| rxValid | input | 1 | A byte from the host is on `rxData` |
| rxData | input | 8 | Received byte |
| txReq | input | 1 | Front end asks for the next byte to send |
| txData | output | 8 | Byte to send, valid while `txReq` is high |
| appReq | output | 1 | Read request forwarded to the application |
| appData | input | 8 | Application's read byte |
| appValid | input | 1 | Application supplies `appData` |
| quickPulse | output | 1 | One-cycle quick-command pulse |
| quickDir | output | 1 | Quick-command direction, 1 = read |
| commitPulse | output | 1 | One-cycle write-commit pulse |
| commitCmd | output | 8 | Command code (buffer entry 0) |
| commitLen | output | $clog2(DEPTH+1) | Number of committed bytes |
| bufIdx | input | $clog2(DEPTH) | Buffer entry select |
| bufByte | output | 8 | Buffer entry at `bufIdx` |
| errPulse | output | 1 | One-cycle protocol-error pulse |

## Verification
Two functions share a cycle when a repeated start into a read follows buffered write bytes. In that cycle the block commits the write block and also enters the read phase. The bench provokes this for every write length from zero to the buffer depth. It expects a commit pulse that carries the correct length, or an error when the length is zero. The very next byte request must then return the application's byte without an error, which proves the read phase was entered as well. A stop asserted together with a received byte is also checked: the commit length must exclude the competing byte.

// File: rtl/smb_seq_pkg.sv
package smb_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_READ,
    ST_DONE,
    ST_CONFUSED
  } seqState_t;

  typedef struct packed {
    logic push;
    logic clrLen;
    logic commit;
  } dpCtl_t;
endpackage

// File: rtl/smb_seq_ctrl.sv
module smb_seq_ctrl
  import smb_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   evStartWr,
  input  logic   evStartRd,
  input  logic   evStop,
  input  logic   evNack,
  input  logic   rxValid,
  input  logic   txReq,
  input  logic   lenZero,
  input  logic   lenFull,
  output dpCtl_t ctl,
  output logic   readActive,
  output logic   appReq,
  output logic   quickPulse,
  output logic   quickDir,
  output logic   errPulse
);
  seqState_t state, nxtState;
  logic quickN, dirN, errN, reqN;

  always_comb begin
    nxtState = state;
    ctl      = '0;
    quickN   = 1'b0;
    dirN     = 1'b0;
    errN     = 1'b0;
    reqN     = 1'b0;
    if (evStop) begin
      if (lenZero) begin
        if (state == ST_WRITE || state == ST_READ) begin
          quickN = 1'b1;
          dirN   = (state == ST_READ);
        end
      end else if (state == ST_WRITE) begin
        ctl.commit = 1'b1;
      end else if (state == ST_READ) begin
        errN = 1'b1;
      end
      ctl.clrLen = 1'b1;
      nxtState   = ST_IDLE;
    end else if (evStartRd) begin
      if (state == ST_IDLE) begin
        nxtState = ST_READ;
      end else if (state == ST_WRITE && !lenZero) begin
        ctl.commit = 1'b1;
        nxtState   = ST_READ;
      end else begin
        nxtState = ST_CONFUSED;
        errN     = 1'b1;
      end
    end else if (evStartWr) begin
      if (state == ST_IDLE) nxtState = ST_WRITE;
      else begin
        nxtState = ST_CONFUSED;
        errN     = 1'b1;
      end
    end else if (evNack) begin
      if (state == ST_READ) nxtState = ST_DONE;
      else if (state != ST_DONE) begin
        nxtState = ST_CONFUSED;
        errN     = 1'b1;
      end
    end else if (rxValid) begin
      if (state == ST_WRITE && !lenFull) ctl.push = 1'b1;
      else errN = 1'b1;
    end else if (txReq) begin
      if (state == ST_READ) reqN = 1'b1;
      else begin
        nxtState = ST_CONFUSED;
        errN     = 1'b1;
      end
    end
  end

  assign readActive = (state == ST_READ);
  assign appReq     = reqN;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      quickPulse <= 1'b0;
      quickDir   <= 1'b0;
      errPulse   <= 1'b0;
    end else begin
      state      <= nxtState;
      quickPulse <= quickN;
      quickDir   <= dirN;
      errPulse   <= errN;
    end
  end

  p_stop_idle_r4: assert property (@(posedge clk) disable iff (rst)
    evStop |=> state == ST_IDLE);
  p_nack_done_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_READ && evNack && !evStop && !evStartRd && !evStartWr) |=> state == ST_DONE);
  p_confused_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CONFUSED && !evStop) |=> state == ST_CONFUSED);
  p_wr_start_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && evStartWr && !evStop && !evStartRd) |=> state == ST_WRITE);
  p_quick_read_dir_r4: assert property (@(posedge clk) disable iff (rst)
    (quickPulse && quickDir) |-> $past(state) == ST_READ);
endmodule

// File: rtl/smb_seq_dpath.sv
module smb_seq_dpath
  import smb_seq_pkg::*;
#(
  parameter int DEPTH = 34,
  localparam int LW = $clog2(DEPTH + 1),
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  dpCtl_t        ctl,
  input  logic [7:0]    rxData,
  input  logic [IW-1:0] bufIdx,
  output logic          lenZero,
  output logic          lenFull,
  output logic          commitPulse,
  output logic [7:0]    commitCmd,
  output logic [LW-1:0] commitLen,
  output logic [7:0]    bufByte
);
  logic [LW-1:0] len;
  logic [7:0]    mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) mem[i] <= '0;
      else if (ctl.push && len == LW'(i)) mem[i] <= rxData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      len         <= '0;
      commitPulse <= 1'b0;
      commitLen   <= '0;
    end else begin
      commitPulse <= ctl.commit;
      if (ctl.commit) commitLen <= len;
      if (ctl.clrLen) len <= '0;
      else if (ctl.push) len <= len + LW'(1);
    end
  end

  assign lenZero   = (len == '0);
  assign lenFull   = (len == LW'(DEPTH));
  assign commitCmd = mem[0];
  assign bufByte   = (int'(bufIdx) < DEPTH) ? mem[bufIdx] : 8'h00;

  p_len_bound_r7: assert property (@(posedge clk) disable iff (rst)
    len <= LW'(DEPTH));
  p_full_nopush_r7: assert property (@(posedge clk) disable iff (rst)
    lenFull |-> !ctl.push);
  p_clear_len_r4: assert property (@(posedge clk) disable iff (rst)
    ctl.clrLen |=> len == '0);
  p_push_grow_r3: assert property (@(posedge clk) disable iff (rst)
    (ctl.push && !ctl.clrLen) |=> len == $past(len) + LW'(1));
  p_cmd_stable_r3: assert property (@(posedge clk) disable iff (rst)
    !(ctl.push && lenZero) |=> $stable(commitCmd));
endmodule

// File: rtl/smb_txn_seq.sv
module smb_txn_seq
  import smb_seq_pkg::*;
#(
  parameter int DEPTH = 34,
  localparam int LW = $clog2(DEPTH + 1),
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          evStartWr,
  input  logic          evStartRd,
  input  logic          evStop,
  input  logic          evNack,
  input  logic          rxValid,
  input  logic [7:0]    rxData,
  input  logic          txReq,
  output logic [7:0]    txData,
  output logic          appReq,
  input  logic [7:0]    appData,
  input  logic          appValid,
  output logic          quickPulse,
  output logic          quickDir,
  output logic          commitPulse,
  output logic [7:0]    commitCmd,
  output logic [LW-1:0] commitLen,
  input  logic [IW-1:0] bufIdx,
  output logic [7:0]    bufByte,
  output logic          errPulse
);
  dpCtl_t ctl;
  logic   lenZero, lenFull, readActive;

  smb_seq_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .evStartWr(evStartWr), .evStartRd(evStartRd), .evStop(evStop),
    .evNack(evNack), .rxValid(rxValid), .txReq(txReq),
    .lenZero(lenZero), .lenFull(lenFull),
    .ctl(ctl), .readActive(readActive), .appReq(appReq),
    .quickPulse(quickPulse), .quickDir(quickDir), .errPulse(errPulse)
  );

  smb_seq_dpath #(.DEPTH(DEPTH)) u_dpath (
    .clk(clk), .rst(rst), .ctl(ctl), .rxData(rxData), .bufIdx(bufIdx),
    .lenZero(lenZero), .lenFull(lenFull),
    .commitPulse(commitPulse), .commitCmd(commitCmd),
    .commitLen(commitLen), .bufByte(bufByte)
  );

  assign txData = (readActive && appValid) ? appData : 8'hFF;

  p_pulse_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(quickPulse && commitPulse));
endmodule

// File: tb/smb_txn_seq_tb.sv
`timescale 1ns/1ps
module smb_txn_seq_tb;
  localparam int DEPTH = 6;
  localparam int LW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic evStartWr = 0, evStartRd = 0, evStop = 0, evNack = 0, rxValid = 0, txReq = 0, appValid = 0;
  logic [7:0] rxData = '0, appData = '0;
  logic [IW-1:0] bufIdx = '0;
  logic [7:0] txData, commitCmd, bufByte;
  logic appReq, quickPulse, quickDir, commitPulse, errPulse;
  logic [LW-1:0] commitLen;

  int checks = 0, errors = 0;
  logic [7:0] sTx;
  logic sReq, sQ, sQd, sC, sE;
  int sLen;
  logic [7:0] sCmd;

  always #2 clk = ~clk;

  smb_txn_seq #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .evStartWr(evStartWr), .evStartRd(evStartRd),
    .evStop(evStop), .evNack(evNack), .rxValid(rxValid), .rxData(rxData),
    .txReq(txReq), .txData(txData), .appReq(appReq), .appData(appData),
    .appValid(appValid), .quickPulse(quickPulse), .quickDir(quickDir),
    .commitPulse(commitPulse), .commitCmd(commitCmd), .commitLen(commitLen),
    .bufIdx(bufIdx), .bufByte(bufByte), .errPulse(errPulse)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int n, input int i);
    return 8'((n * 37 + i * 11 + 5) & 255);
  endfunction

  // one cycle: drive at negedge, sample combinational after 1ns, registered after the edge
  task automatic step(input logic sw, input logic sr, input logic sp, input logic nk,
                      input logic rx, input logic [7:0] d, input logic tq,
                      input logic [7:0] ad, input logic av);
    @(negedge clk);
    evStartWr = sw; evStartRd = sr; evStop = sp; evNack = nk;
    rxValid = rx; rxData = d; txReq = tq; appData = ad; appValid = av;
    #1;
    sTx = txData; sReq = appReq;
    @(posedge clk);
    #1;
    sQ = quickPulse; sQd = quickDir; sC = commitPulse; sE = errPulse;
    sLen = int'(commitLen); sCmd = commitCmd;
    evStartWr = 0; evStartRd = 0; evStop = 0; evNack = 0; rxValid = 0; txReq = 0;
  endtask

  task automatic doWr();    step(1,0,0,0,0,8'h00,0,8'h00,0); endtask
  task automatic doRd();    step(0,1,0,0,0,8'h00,0,8'h00,0); endtask
  task automatic doStop();  step(0,0,1,0,0,8'h00,0,8'h00,0); endtask
  task automatic doNack();  step(0,0,0,1,0,8'h00,0,8'h00,0); endtask
  task automatic doRx(input logic [7:0] d); step(0,0,0,0,1,d,0,8'h00,0); endtask
  task automatic doTx(input logic [7:0] ad, input logic av); step(0,0,0,0,0,8'h00,1,ad,av); endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    // R1 reset state
    chk(!quickPulse && !commitPulse && !errPulse, "R1", int'({quickPulse,commitPulse,errPulse}), 0);
    chk(txData == 8'hFF, "R1", int'(txData), 255);

    // Sweep write lengths: R2 R3 R4 R7
    for (int n = 0; n <= DEPTH + 2; n++) begin
      doWr();
      chk(!sE, "R2", int'(sE), 0);
      for (int i = 0; i < n; i++) begin
        doRx(pat(n, i));
        chk(sE == (i >= DEPTH), "R7", int'(sE), int'(i >= DEPTH));
      end
      doStop();
      if (n == 0) begin
        chk(sQ && !sQd && !sC, "R4", int'({sQ,sQd,sC}), 4);
      end else begin
        chk(sC && !sQ && !sE, "R3", int'({sC,sQ,sE}), 4);
        chk(sLen == ((n < DEPTH) ? n : DEPTH), "R7", sLen, (n < DEPTH) ? n : DEPTH);
        chk(sCmd == pat(n, 0), "R3", int'(sCmd), int'(pat(n, 0)));
        for (int i = 0; i < ((n < DEPTH) ? n : DEPTH); i++) begin
          bufIdx = IW'(i);
          #0.1;
          chk(bufByte == pat(n, i), "R3", int'(bufByte), int'(pat(n, i)));
        end
      end
    end

    // Repeated start sweep: R5 R6 R8 R10
    for (int n = 0; n <= DEPTH; n++) begin
      doWr();
      for (int i = 0; i < n; i++) doRx(pat(n + 50, i));
      doRd();
      if (n == 0) begin
        chk(sE && !sC, "R5", int'({sE,sC}), 2);
        doTx(8'h12, 1);
        chk(sTx == 8'hFF && sE && !sReq, "R8", int'(sTx), 255);
        doStop();
        chk(!sQ && !sC && !sE, "R11", int'({sQ,sC,sE}), 0);
      end else begin
        chk(sC && !sE && sLen == n, "R5", sLen, n);
        doTx(8'(8'hA0 + n), 1);
        chk(sTx == 8'(8'hA0 + n) && sReq && !sE, "R8", int'(sTx), int'(8'(8'hA0 + n)));
        doTx(8'h33, 0);
        chk(sTx == 8'hFF && !sE, "R8", int'(sTx), 255);
        if (n % 2 == 0) begin
          doNack();
          chk(!sE, "R6", int'(sE), 0);
          doNack();
          chk(!sE, "R6", int'(sE), 0);
          doStop();
          chk(!sQ && !sC && !sE, "R10", int'({sQ,sC,sE}), 0);
        end else begin
          doStop();
          chk(sE && !sQ && !sC, "R10", int'({sE,sQ,sC}), 4);
        end
      end
    end

    // Quick read and ignored received byte: R4 R9
    doRd();
    doRx(8'h77);
    chk(sE, "R9", int'(sE), 1);
    doStop();
    chk(sQ && sQd && !sC, "R4", int'({sQ,sQd,sC}), 6);

    // NACK outside read, confused persistence: R6 R11
    doNack();
    chk(sE, "R6", int'(sE), 1);
    doWr();
    chk(sE, "R11", int'(sE), 1);
    doRd();
    chk(sE, "R11", int'(sE), 1);
    doTx(8'h44, 1);
    chk(sTx == 8'hFF && sE, "R11", int'(sTx), 255);
    doStop();
    chk(!sQ && !sC && !sE, "R11", int'({sQ,sC,sE}), 0);

    // Start-write outside idle: R2
    doWr();
    doWr();
    chk(sE, "R2", int'(sE), 1);
    doStop();

    // Priority: stop beats received byte; start-read beats start-write: R12
    doWr();
    doRx(8'h55);
    step(0,0,1,0,1,8'h66,0,8'h00,0);
    chk(sC && sLen == 1 && !sE && sCmd == 8'h55, "R12", sLen, 1);
    step(1,1,0,0,0,8'h00,0,8'h00,0);
    chk(!sE, "R12", int'(sE), 0);
    doTx(8'h99, 1);
    chk(sTx == 8'h99 && !sE, "R12", int'(sTx), 153);
    doStop();
    chk(sQ && sQd, "R12", int'({sQ,sQd}), 3);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule